// File: doc/BRIEF.md
# Dual-Rail Four-Phase Word Link

This block carries a W-bit word across a two-wires-per-bit channel. No separate request wire is used. Each bit occupies one wire pair. A pair at rest holds the spacer code. When a word is sent, each pair moves to a code that means zero or one. The transmit half steps through a four-phase, return-to-zero cycle with a small state machine. It drives the encoded word, waits for acknowledge, returns every pair to the spacer, then waits for acknowledge to drop before it takes the next word.

The receive half watches all pairs at once. It treats a word as arrived only when every pair holds a legal data code. It then captures the decoded word, pulses a strobe and raises acknowledge. It lowers acknowledge once every pair has gone back to the spacer. A pair that shows the unused code sets a sticky error flag.

Both halves use clocked sampling. The channel wires come out on top-level ports in both directions, so the two halves can be joined directly, or with a delay or fault placed between them.

Top module: `dr_link_top`

## Requirements
- R1: Pair i is rails[2i+1:2i]. Code 00 is the spacer, 01 carries a one, 10 carries a zero, and 11 is illegal. The transmitter never drives 11.
- R2: After synchronous reset, tx_rails is all zero, rx_ack is 0, tx_ready is 1, rx_err is 0, rx_strobe is 0 and rx_word is 0.
- R3: The receiver raises rx_ack only when every pair holds 01 or 10. A word with any pair still at 00 produces neither acknowledge nor strobe.
- R4: When a word completes, rx_word takes the decoded value and rx_strobe is high for exactly one cycle. rx_word then holds until the next word completes, including across the spacer phase.
- R5: The receiver lowers rx_ack only when every pair is 00. While any pair is still non-zero, rx_ack stays high.
- R6: The transmitter holds the encoded word on tx_rails until it samples tx_ack high. On the next cycle it drives every pair to 00.
- R7: The transmitter accepts tx_valid only while tx_ready is high and tx_ack is low. It returns to ready only after it samples tx_ack low in the spacer phase. A tx_valid seen while busy is ignored.
- R8: Any pair sampled at 11 sets rx_err, and only reset clears it. A word that contains an illegal pair does not complete.
- R9: With the channel joined straight through, rx_strobe is high in the second cycle after the edge that accepts tx_valid, and tx_ready is high again four cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Request to send tx_data |
| tx_data | input | W | Word to send |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| tx_rails | output | 2W | Encoded channel pairs driven by the transmitter |
| tx_ack | input | 1 | Acknowledge as seen by the transmitter |
| rx_rails | input | 2W | Channel pairs as seen by the receiver |
| rx_ack | output | 1 | Acknowledge driven by the receiver |
| rx_word | output | W | Last completed word |
| rx_strobe | output | 1 | One-cycle pulse on word completion |
| rx_err | output | 1 | Sticky illegal-code flag |

## Verification
The bench builds the block with W = 8. At that width a walking-one pattern exercises every pair in both data codes, and all-zero and all-one words reach the extremes of the encoder. Because the channel is joined in the bench, the bench can override either direction. This lets it hold acknowledge low to stall the transmitter, present partially filled words and partial spacers to the receiver, and place the illegal code on a single pair.

// File: rtl/dr_link_pkg.sv
package dr_link_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_DRIVE, TX_SPACER} tx_state_e;
  typedef enum logic {RX_WAIT_WORD, RX_WAIT_SPACER} rx_state_e;
  localparam logic [1:0] CODE_SPACER = 2'b00;
  localparam logic [1:0] CODE_ONE    = 2'b01;
  localparam logic [1:0] CODE_ZERO   = 2'b10;
  localparam logic [1:0] CODE_BAD    = 2'b11;
endpackage

// File: rtl/dr_encoder.sv
module dr_encoder #(
  parameter int W = 8
) (
  input  logic [W-1:0]   bits,
  output logic [2*W-1:0] rails
);
  import dr_link_pkg::*;
  for (genvar i = 0; i < W; i++) begin : g_pair
    assign rails[2*i +: 2] = bits[i] ? CODE_ONE : CODE_ZERO;
  end
endmodule

// File: rtl/dr_completion.sv
module dr_completion #(
  parameter int W = 8
) (
  input  logic [2*W-1:0] rails,
  output logic           all_valid,
  output logic           all_spacer,
  output logic           any_bad,
  output logic [W-1:0]   bits
);
  import dr_link_pkg::*;
  logic [W-1:0] valid_v, zero_v, bad_v;
  for (genvar i = 0; i < W; i++) begin : g_pair
    assign valid_v[i] = (rails[2*i +: 2] == CODE_ONE) || (rails[2*i +: 2] == CODE_ZERO);
    assign zero_v[i]  = (rails[2*i +: 2] == CODE_SPACER);
    assign bad_v[i]   = (rails[2*i +: 2] == CODE_BAD);
    assign bits[i]    = (rails[2*i +: 2] == CODE_ONE);
  end
  assign all_valid  = &valid_v;
  assign all_spacer = &zero_v;
  assign any_bad    = |bad_v;
endmodule

// File: rtl/dr_sender.sv
module dr_sender #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tx_valid,
  input  logic [W-1:0]   tx_data,
  output logic           tx_ready,
  output logic [2*W-1:0] tx_rails,
  input  logic           ack_in
);
  import dr_link_pkg::*;
  tx_state_e     st;
  logic [2*W-1:0] enc;
  logic           accept;

  dr_encoder #(.W(W)) u_enc (.bits(tx_data), .rails(enc));

  assign accept = tx_valid && tx_ready && !ack_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TX_IDLE;
      tx_rails <= '0;
      tx_ready <= 1'b1;
    end else begin
      case (st)
        TX_IDLE: if (accept) begin
          st       <= TX_DRIVE;
          tx_rails <= enc;
          tx_ready <= 1'b0;
        end
        TX_DRIVE: if (ack_in) begin
          st       <= TX_SPACER;
          tx_rails <= '0;
        end
        TX_SPACER: if (!ack_in) begin
          st       <= TX_IDLE;
          tx_ready <= 1'b1;
        end
        default: begin
          st       <= TX_IDLE;
          tx_rails <= '0;
          tx_ready <= 1'b1;
        end
      endcase
    end
  end

  logic [W-1:0] tx_bad;
  for (genvar i = 0; i < W; i++) begin : g_chk
    assign tx_bad[i] = (tx_rails[2*i +: 2] == CODE_BAD);
  end

  AST_TX_NO_BAD: assert property (@(posedge clk) disable iff (rst)
    tx_bad == '0); // R1
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == TX_DRIVE && !ack_in) |=> $stable(tx_rails)); // R6
  AST_TX_SPACER_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (st == TX_DRIVE && ack_in) |=> (tx_rails == '0)); // R6
  AST_TX_NEW_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
    (tx_rails != '0 && $past(tx_rails) == '0) |-> !$past(ack_in)); // R7
endmodule

// File: rtl/dr_receiver.sv
module dr_receiver #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*W-1:0] rx_rails,
  output logic           rx_ack,
  output logic [W-1:0]   rx_word,
  output logic           rx_strobe,
  output logic           rx_err
);
  import dr_link_pkg::*;
  rx_state_e    st;
  logic         all_valid, all_spacer, any_bad;
  logic [W-1:0] dec;

  dr_completion #(.W(W)) u_cd (
    .rails(rx_rails), .all_valid(all_valid), .all_spacer(all_spacer),
    .any_bad(any_bad), .bits(dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RX_WAIT_WORD;
      rx_ack    <= 1'b0;
      rx_word   <= '0;
      rx_strobe <= 1'b0;
      rx_err    <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      if (any_bad) rx_err <= 1'b1;
      case (st)
        RX_WAIT_WORD: if (all_valid) begin
          st        <= RX_WAIT_SPACER;
          rx_ack    <= 1'b1;
          rx_word   <= dec;
          rx_strobe <= 1'b1;
        end
        RX_WAIT_SPACER: if (all_spacer) begin
          st     <= RX_WAIT_WORD;
          rx_ack <= 1'b0;
        end
        default: begin
          st     <= RX_WAIT_WORD;
          rx_ack <= 1'b0;
        end
      endcase
    end
  end

  AST_ACK_RISE_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ack) |-> $past(all_valid)); // R3
  AST_ACK_FALL_SPACER: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_ack) |-> $past(all_spacer)); // R5
  AST_WORD_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_word) |-> rx_strobe); // R4
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |=> !rx_strobe); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    rx_err |=> rx_err); // R8
endmodule

// File: rtl/dr_link_top.sv
module dr_link_top #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tx_valid,
  input  logic [W-1:0]   tx_data,
  output logic           tx_ready,
  output logic [2*W-1:0] tx_rails,
  input  logic           tx_ack,
  input  logic [2*W-1:0] rx_rails,
  output logic           rx_ack,
  output logic [W-1:0]   rx_word,
  output logic           rx_strobe,
  output logic           rx_err
);
  dr_sender #(.W(W)) u_tx (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_rails(tx_rails), .ack_in(tx_ack)
  );

  dr_receiver #(.W(W)) u_rx (
    .clk(clk), .rst(rst), .rx_rails(rx_rails), .rx_ack(rx_ack),
    .rx_word(rx_word), .rx_strobe(rx_strobe), .rx_err(rx_err)
  );
endmodule

// File: tb/tb_dr_link_top.sv
module tb_dr_link_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_valid = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic tx_ready, rx_ack, rx_strobe, rx_err;
  logic [2*W-1:0] tx_rails, rx_rails_in;
  logic [W-1:0] rx_word;
  logic tx_ack_in;

  logic ovr_en = 1'b0;
  logic [2*W-1:0] ovr_rails = '0;
  logic ack_ovr_en = 1'b0;
  logic ack_ovr = 1'b0;

  assign rx_rails_in = ovr_en ? ovr_rails : tx_rails;
  assign tx_ack_in   = ack_ovr_en ? ack_ovr : rx_ack;

  always #5 clk = ~clk;

  dr_link_top #(.W(W)) dut (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_rails(tx_rails), .tx_ack(tx_ack_in),
    .rx_rails(rx_rails_in), .rx_ack(rx_ack), .rx_word(rx_word),
    .rx_strobe(rx_strobe), .rx_err(rx_err)
  );

  int vec_cnt = 0;
  int fail_cnt = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_q[$];

  function automatic logic [2*W-1:0] enc(input logic [W-1:0] d);
    logic [2*W-1:0] r;
    for (int i = 0; i < W; i++) r[2*i +: 2] = d[i] ? 2'b01 : 2'b10;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected words as strobes appear
  always @(negedge clk) begin
    if (!rst && rx_strobe) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected strobe", {24'd0, rx_word}, 32'd0);
      else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(rx_word == e, "R4 word", {24'd0, rx_word}, {24'd0, e});
      end
    end
  end

  task automatic wait_ready();
    for (int k = 0; k < 20; k++) begin
      if (tx_ready) return;
      @(negedge clk);
    end
  endtask

  // Driver: loopback send with R9 timing
  task automatic send_word(input logic [W-1:0] d);
    wait_ready();
    exp_q.push_back(d);
    tx_valid = 1'b1; tx_data = d;
    @(posedge clk); #1 tx_valid = 1'b0;
    @(negedge clk);
    chk(rx_strobe == 1'b0, "R9 strobe early", {31'd0, rx_strobe}, 32'd0);
    chk(tx_rails == enc(d), "R1 encoding", {16'd0, tx_rails}, {16'd0, enc(d)});
    @(negedge clk);
    chk(rx_strobe == 1'b1, "R9 strobe cycle", {31'd0, rx_strobe}, 32'd1);
    @(negedge clk); @(negedge clk);
    chk(tx_ready == 1'b0, "R9 ready early", {31'd0, tx_ready}, 32'd0);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R9 ready return", {31'd0, tx_ready}, 32'd1);
    chk(rx_word == d, "R4 word held", {24'd0, rx_word}, {24'd0, d});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fail_cnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    chk(tx_rails == '0, "R2 rails", {16'd0, tx_rails}, 32'd0);
    chk(rx_ack == 1'b0, "R2 ack", {31'd0, rx_ack}, 32'd0);
    chk(tx_ready == 1'b1, "R2 ready", {31'd0, tx_ready}, 32'd1);
    chk(rx_err == 1'b0, "R2 err", {31'd0, rx_err}, 32'd0);
    chk(rx_strobe == 1'b0 && rx_word == '0, "R2 word", {24'd0, rx_word}, 32'd0);

    // Loopback words
    send_word(8'h00);
    send_word(8'hFF);
    send_word(8'hA5);
    send_word(8'h5A);
    for (int i = 0; i < W; i++) send_word(8'h01 << i);

    // R6/R7: stall transmitter with ack held low, receiver blind
    ovr_en = 1'b1; ovr_rails = '0; ack_ovr_en = 1'b1; ack_ovr = 1'b0;
    tx_valid = 1'b1; tx_data = 8'h3C;
    @(posedge clk); #1 tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_rails == enc(8'h3C), "R6 hold word", {16'd0, tx_rails}, {16'd0, enc(8'h3C)});
    chk(tx_ready == 1'b0, "R7 busy", {31'd0, tx_ready}, 32'd0);
    tx_valid = 1'b1; tx_data = 8'hC3;
    @(negedge clk); tx_valid = 1'b0;
    chk(tx_rails == enc(8'h3C), "R7 ignored while busy", {16'd0, tx_rails}, {16'd0, enc(8'h3C)});
    ack_ovr = 1'b1;
    @(negedge clk);
    chk(tx_rails == '0, "R6 spacer after ack", {16'd0, tx_rails}, 32'd0);
    repeat (2) @(negedge clk);
    chk(tx_ready == 1'b0, "R7 waits ack low", {31'd0, tx_ready}, 32'd0);
    ack_ovr = 1'b0;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R7 ready after ack low", {31'd0, tx_ready}, 32'd1);
    @(negedge clk);
    chk(tx_rails == '0, "R7 no stray word", {16'd0, tx_rails}, 32'd0);
    ack_ovr_en = 1'b0;

    // R3: partial word, top pair still spacer
    ovr_rails = enc(8'h96);
    ovr_rails[2*W-1 -: 2] = 2'b00;
    repeat (3) @(negedge clk);
    chk(rx_ack == 1'b0, "R3 partial no ack", {31'd0, rx_ack}, 32'd0);
    exp_q.push_back(8'h96);
    ovr_rails = enc(8'h96);
    @(negedge clk);
    chk(rx_ack == 1'b1, "R3 full word ack", {31'd0, rx_ack}, 32'd1);
    // R5: partial spacer keeps ack
    ovr_rails = '0; ovr_rails[1:0] = 2'b10;
    repeat (3) @(negedge clk);
    chk(rx_ack == 1'b1, "R5 partial spacer", {31'd0, rx_ack}, 32'd1);
    ovr_rails = '0;
    @(negedge clk);
    chk(rx_ack == 1'b0, "R5 ack drop", {31'd0, rx_ack}, 32'd0);
    chk(rx_word == 8'h96, "R4 held after spacer", {24'd0, rx_word}, 32'h96);

    // R8: illegal pair
    ovr_rails = enc(8'h0F); ovr_rails[5:4] = 2'b11;
    repeat (2) @(negedge clk);
    chk(rx_err == 1'b1, "R8 err set", {31'd0, rx_err}, 32'd1);
    chk(rx_ack == 1'b0, "R8 no completion", {31'd0, rx_ack}, 32'd0);
    ovr_rails = '0;
    repeat (2) @(negedge clk);
    chk(rx_err == 1'b1, "R8 err sticky", {31'd0, rx_err}, 32'd1);
    chk(rx_word == 8'h96, "R8 word untouched", {24'd0, rx_word}, 32'h96);
    ovr_en = 1'b0;
    send_word(8'h77);
    chk(rx_err == 1'b1, "R8 err still set", {31'd0, rx_err}, 32'd1);
    do_reset();
    chk(rx_err == 1'b0, "R8 reset clears err", {31'd0, rx_err}, 32'd0);
    chk(exp_q.size() == 0, "R4 all words seen", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, fail_cnt);
    $finish;
  end
endmodule